// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block sits at the retire stage of an in-order-retiring processor pipeline and decides, one cycle at a time, whether an exception is taken, which one, and what state is saved for the handler. It sees the instruction now retiring (valid flag, address, kind, and a mask of detected fault conditions), a set of asynchronous interrupt request lines, the empty flag of the completed-store queue, the floating-point exception mode bits, a return-from-exception strobe, and the two preempting events: machine check and system reset.

When an exception is taken, the block pulses a take and a flush output, presents a vector number shared by related conditions, and presents a finer cause code. It saves a return address and a copy of the machine state, and clears the interrupt-enable bit of the live machine state. A fault is taken before the instruction, and anything younger, can complete. An instruction with several faults has them delivered one per handler entry. Interrupt requests are held until the pipeline reaches a clean boundary. A return-from-exception restores the saved machine state and publishes the saved address as the resume point.

Top module: `exc_commit_ctrl`

## Requirements
- R1: While rst_n is low and just after it rises, take_o, flush_o and resume_o are 0, srr_pc_o and srr_msr_o are 0, and msr_o equals MSR_RESET (default 1: bit 0 is the interrupt-enable bit, set).
- R2: A valid retiring instruction with a nonzero fault mask has retire_ok_o low in that cycle. On the next cycle take_o and flush_o pulse with srr_pc_o equal to its address. For the lowest set fault bit i, cause_o is 0x10+i and vec_o is 4+(i/2), so fault bits 0 and 1 share vector 4 and bits 2 and 3 share vector 5.
- R3: Fault bits that are not taken stay pending. One cycle after the resume pulse that ends the handler, the next lowest pending bit is taken with the same saved address. Each bit is delivered once.
- R4: A retiring instruction of kind 1 (trap) or kind 2 (system call) with no fault bits completes (retire_ok_o high). It is taken next cycle with vec_o 12 or 13 and cause_o 0x04 or 0x05, and srr_pc_o is its address plus 4.
- R5: An interrupt request pulse on line j is held. It is taken only when msr bit 0 is set and sq_empty_i is high, with vec_o 3, cause_o 0x08+j (lowest j first). srr_pc_o is the retiring address plus 4 if an instruction completes in that cycle, otherwise the last resume or completion address.
- R6: When a fault on the retiring instruction and an eligible held interrupt occur in the same cycle, the fault is taken and the interrupt stays held for later.
- R7: On every exception entry, srr_msr_o takes the prior msr_o and msr_o bit 0 is cleared.
- R8: A return-from-exception with no exception taken in that cycle pulses resume_o on the next cycle and restores msr_o from srr_msr_o, and srr_pc_o gives the resume address.
- R9: mchk_i is taken on the next cycle regardless of interrupt enable or an active handler (vec 2, cause 0x02), and the retiring instruction does not complete. rst_req_i outranks it (vec 1, cause 0x01) and discards pending fault bits. Both save the retiring address, or the last resume or completion address when none is retiring.
- R10: The floating-point mode input has no effect: every mode gives the same retire_ok_o, vector, cause and saved address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ret_valid_i | input | 1 | An instruction is at the retire stage |
| ret_pc_i | input | AW | Address of the retiring instruction |
| ret_kind_i | input | 2 | 0 normal, 1 trap, 2 system call |
| ret_cond_i | input | NC | Fault conditions detected for the retiring instruction |
| irq_i | input | NI | Asynchronous interrupt request pulses |
| sq_empty_i | input | 1 | Completed-store queue is empty |
| fp_mode_i | input | 2 | Floating-point exception mode (no effect) |
| rfe_i | input | 1 | Return-from-exception strobe |
| mchk_i | input | 1 | Machine check event |
| rst_req_i | input | 1 | System reset event |
| retire_ok_o | output | 1 | Retiring instruction may complete this cycle |
| take_o | output | 1 | Exception taken (one-cycle pulse) |
| flush_o | output | 1 | Pipeline flush (one-cycle pulse) |
| vec_o | output | 4 | Vector number of the taken exception |
| cause_o | output | 5 | Specific cause code of the taken exception |
| srr_pc_o | output | AW | Saved return address |
| srr_msr_o | output | SW | Saved machine state |
| msr_o | output | SW | Live machine state |
| resume_o | output | 1 | Resume pulse after return-from-exception |

## Verification
The interesting collision is a fault on the retiring instruction arriving in the very cycle a held interrupt becomes eligible. The bench latches an interrupt while the store queue is busy, then releases the queue in the cycle a faulting instruction retires. The fault's cause and address must be reported first, and the interrupt must appear only after the handler returns, saving the faulting address as the resume point. A second collision puts a machine check on top of a retiring instruction and an active handler, and is judged by retire_ok_o dropping and the machine-check vector replacing everything else.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int VEC_W   = 4;
    localparam int CAUSE_W = 5;

    typedef enum logic [1:0] {
        KIND_NORMAL  = 2'd0,
        KIND_TRAP    = 2'd1,
        KIND_SYSCALL = 2'd2
    } kind_e;

    localparam logic [VEC_W-1:0] VEC_RESET     = 4'd1;
    localparam logic [VEC_W-1:0] VEC_MCHK      = 4'd2;
    localparam logic [VEC_W-1:0] VEC_IRQ       = 4'd3;
    localparam logic [VEC_W-1:0] VEC_COND_BASE = 4'd4;
    localparam logic [VEC_W-1:0] VEC_TRAP      = 4'd12;
    localparam logic [VEC_W-1:0] VEC_SYSCALL   = 4'd13;

    localparam logic [CAUSE_W-1:0] CAUSE_RESET     = 5'h01;
    localparam logic [CAUSE_W-1:0] CAUSE_MCHK      = 5'h02;
    localparam logic [CAUSE_W-1:0] CAUSE_TRAP      = 5'h04;
    localparam logic [CAUSE_W-1:0] CAUSE_SYSCALL   = 5'h05;
    localparam logic [CAUSE_W-1:0] CAUSE_IRQ_BASE  = 5'h08;
    localparam logic [CAUSE_W-1:0] CAUSE_COND_BASE = 5'h10;

endpackage

// File: rtl/exc_lowbit_pick.sv
module exc_lowbit_pick #(
    parameter int W  = 4,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o,
    output logic [W-1:0]  grant_o
);

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_grant
            if (g == 0) begin : g_first
                assign grant_o[g] = req_i[g];
            end else begin : g_rest
                assign grant_o[g] = req_i[g] & ~(|req_i[g-1:0]);
            end
        end
    endgenerate

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (grant_o[i]) idx_o = idx_o | IW'(i);
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/exc_code_map.sv
module exc_code_map
    import exc_pkg::*;
#(
    parameter int IW = 2
) (
    input  logic [IW-1:0]      idx_i,
    input  logic               is_irq_i,
    output logic [VEC_W-1:0]   vec_o,
    output logic [CAUSE_W-1:0] cause_o
);

    logic [VEC_W-1:0] idx_ext;

    always_comb begin
        idx_ext = VEC_W'(idx_i);
        if (is_irq_i) begin
            vec_o   = VEC_IRQ;
            cause_o = CAUSE_IRQ_BASE + CAUSE_W'(idx_ext);
        end else begin
            vec_o   = VEC_COND_BASE + (idx_ext >> 1);
            cause_o = CAUSE_COND_BASE + CAUSE_W'(idx_ext);
        end
    end

endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
    import exc_pkg::*;
#(
    parameter int              AW        = 32,
    parameter int              SW        = 8,
    parameter int              NC        = 4,
    parameter int              NI        = 2,
    parameter int              EE_BIT    = 0,
    parameter logic [SW-1:0]   MSR_RESET = 8'h01,
    parameter logic [AW-1:0]   PC_RESET  = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ret_valid_i,
    input  logic [AW-1:0]      ret_pc_i,
    input  logic [1:0]         ret_kind_i,
    input  logic [NC-1:0]      ret_cond_i,
    input  logic [NI-1:0]      irq_i,
    input  logic               sq_empty_i,
    input  logic [1:0]         fp_mode_i,
    input  logic               rfe_i,
    input  logic               mchk_i,
    input  logic               rst_req_i,
    output logic               retire_ok_o,
    output logic               take_o,
    output logic               flush_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [AW-1:0]      srr_pc_o,
    output logic [SW-1:0]      srr_msr_o,
    output logic [SW-1:0]      msr_o,
    output logic               resume_o
);

    localparam int CIW = (NC > 1) ? $clog2(NC) : 1;
    localparam int IIW = (NI > 1) ? $clog2(NI) : 1;
    localparam logic [AW-1:0] STEP = AW'(4);

    typedef struct packed {
        logic               take;
        logic               resume;
        logic [VEC_W-1:0]   vec;
        logic [CAUSE_W-1:0] cause;
        logic [AW-1:0]      srr_pc;
        logic [SW-1:0]      srr_msr;
        logic [SW-1:0]      msr;
        logic [AW-1:0]      nxt_pc;
        logic [NC-1:0]      pend;
        logic [AW-1:0]      pend_pc;
        logic [NI-1:0]      irq;
        logic               in_exc;
    } state_t;

    state_t s_d, s_q;

    // priority pickers: held faults, new faults, held interrupts
    logic            pend_any, cond_any, irq_any;
    logic [CIW-1:0]  pend_idx, cond_idx;
    logic [IIW-1:0]  irq_idx;
    logic [NC-1:0]   pend_gnt, cond_gnt;
    logic [NI-1:0]   irq_gnt;

    exc_lowbit_pick #(.W(NC), .IW(CIW)) u_pick_pend (
        .req_i(s_q.pend), .any_o(pend_any), .idx_o(pend_idx), .grant_o(pend_gnt));
    exc_lowbit_pick #(.W(NC), .IW(CIW)) u_pick_cond (
        .req_i(ret_cond_i), .any_o(cond_any), .idx_o(cond_idx), .grant_o(cond_gnt));
    exc_lowbit_pick #(.W(NI), .IW(IIW)) u_pick_irq (
        .req_i(s_q.irq), .any_o(irq_any), .idx_o(irq_idx), .grant_o(irq_gnt));

    logic [VEC_W-1:0]   pend_vec, cond_vec, irq_vec;
    logic [CAUSE_W-1:0] pend_cause, cond_cause, irq_cause;

    exc_code_map #(.IW(CIW)) u_map_pend (
        .idx_i(pend_idx), .is_irq_i(1'b0), .vec_o(pend_vec), .cause_o(pend_cause));
    exc_code_map #(.IW(CIW)) u_map_cond (
        .idx_i(cond_idx), .is_irq_i(1'b0), .vec_o(cond_vec), .cause_o(cond_cause));
    exc_code_map #(.IW(IIW)) u_map_irq (
        .idx_i(irq_idx), .is_irq_i(1'b1), .vec_o(irq_vec), .cause_o(irq_cause));

    logic fault, sys_call, pend_take, irq_take, take_now, retire_ok;
    logic [AW-1:0] cur_pc;

    always_comb begin
        s_d        = s_q;
        s_d.take   = 1'b0;
        s_d.resume = 1'b0;
        s_d.irq    = s_q.irq | irq_i;

        // floating-point faults arrive in ret_cond_i and are always taken
        // precisely: the mode bits select nothing here
        fault     = ret_valid_i && cond_any;
        sys_call  = ret_valid_i && !cond_any && (ret_kind_i != KIND_NORMAL);
        pend_take = pend_any && !s_q.in_exc;
        retire_ok = ret_valid_i && !cond_any && !rst_req_i && !mchk_i && !pend_take;
        irq_take  = irq_any && s_q.msr[EE_BIT] && sq_empty_i;
        cur_pc    = ret_valid_i ? ret_pc_i : s_q.nxt_pc;
        take_now  = 1'b1;

        if (retire_ok) s_d.nxt_pc = ret_pc_i + STEP;

        if (rst_req_i) begin
            s_d.vec    = VEC_RESET;
            s_d.cause  = CAUSE_RESET;
            s_d.srr_pc = cur_pc;
            s_d.pend   = '0;
            s_d.irq    = '0;
        end else if (mchk_i) begin
            s_d.vec    = VEC_MCHK;
            s_d.cause  = CAUSE_MCHK;
            s_d.srr_pc = cur_pc;
        end else if (pend_take) begin
            s_d.vec    = pend_vec;
            s_d.cause  = pend_cause;
            s_d.srr_pc = s_q.pend_pc;
            s_d.pend   = s_q.pend & ~pend_gnt;
        end else if (fault) begin
            s_d.vec     = cond_vec;
            s_d.cause   = cond_cause;
            s_d.srr_pc  = ret_pc_i;
            s_d.pend    = ret_cond_i & ~cond_gnt;
            s_d.pend_pc = ret_pc_i;
        end else if (sys_call) begin
            s_d.vec    = (ret_kind_i == KIND_TRAP) ? VEC_TRAP : VEC_SYSCALL;
            s_d.cause  = (ret_kind_i == KIND_TRAP) ? CAUSE_TRAP : CAUSE_SYSCALL;
            s_d.srr_pc = ret_pc_i + STEP;
        end else if (irq_take) begin
            s_d.vec    = irq_vec;
            s_d.cause  = irq_cause;
            s_d.srr_pc = retire_ok ? (ret_pc_i + STEP) : s_q.nxt_pc;
            s_d.irq    = s_d.irq & ~irq_gnt;
        end else begin
            take_now = 1'b0;
        end

        if (take_now) begin
            s_d.take           = 1'b1;
            s_d.srr_msr        = s_q.msr;
            s_d.msr[EE_BIT]    = 1'b0;
            s_d.in_exc         = 1'b1;
        end else if (rfe_i) begin
            s_d.msr    = s_q.srr_msr;
            s_d.in_exc = 1'b0;
            s_d.resume = 1'b1;
            s_d.nxt_pc = s_q.srr_pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.msr    <= MSR_RESET;
            s_q.nxt_pc <= PC_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign retire_ok_o = retire_ok;
    assign take_o      = s_q.take;
    assign flush_o     = s_q.take;
    assign vec_o       = s_q.vec;
    assign cause_o     = s_q.cause;
    assign srr_pc_o    = s_q.srr_pc;
    assign srr_msr_o   = s_q.srr_msr;
    assign msr_o       = s_q.msr;
    assign resume_o    = s_q.resume;

    // R2: a faulting instruction never completes
    p_fault_blocks_retire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid_i && ret_cond_i != '0) |-> !retire_ok_o);

    // R3: a delivered fault bit is no longer pending
    p_pend_bit_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && cause_o >= CAUSE_COND_BASE) |-> !s_q.pend[cause_o[CIW-1:0]]);

    // R5: held interrupts only leave with a drained store queue
    p_irq_needs_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vec_o == VEC_IRQ) |-> $past(sq_empty_i));

    // R7: entry always clears the interrupt-enable bit
    p_entry_clears_ee_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !msr_o[EE_BIT]);

    // R8: return restores the saved state
    p_rfe_restores_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe_i && !take_now) |=> (msr_o == $past(srr_msr_o)) && resume_o);

    // R9: machine check is never deferred
    p_mchk_immediate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mchk_i |=> take_o);

    // R10: imprecise modes still hold back a faulting instruction
    p_fp_mode_precise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid_i && ret_cond_i != '0 && fp_mode_i != 2'b00) |-> !retire_ok_o);

endmodule

// File: tb/exc_commit_ctrl_tb_top.sv
module exc_commit_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ret_valid_i = 1'b0;
    logic [31:0] ret_pc_i = '0;
    logic [1:0]  ret_kind_i = '0;
    logic [3:0]  ret_cond_i = '0;
    logic [1:0]  irq_i = '0;
    logic        sq_empty_i = 1'b1;
    logic [1:0]  fp_mode_i = '0;
    logic        rfe_i = 1'b0;
    logic        mchk_i = 1'b0;
    logic        rst_req_i = 1'b0;
    logic        retire_ok_o, take_o, flush_o, resume_o;
    logic [3:0]  vec_o;
    logic [4:0]  cause_o;
    logic [31:0] srr_pc_o;
    logic [7:0]  srr_msr_o, msr_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    exc_commit_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .ret_valid_i(ret_valid_i), .ret_pc_i(ret_pc_i), .ret_kind_i(ret_kind_i),
        .ret_cond_i(ret_cond_i), .irq_i(irq_i), .sq_empty_i(sq_empty_i),
        .fp_mode_i(fp_mode_i), .rfe_i(rfe_i), .mchk_i(mchk_i), .rst_req_i(rst_req_i),
        .retire_ok_o(retire_ok_o), .take_o(take_o), .flush_o(flush_o),
        .vec_o(vec_o), .cause_o(cause_o), .srr_pc_o(srr_pc_o),
        .srr_msr_o(srr_msr_o), .msr_o(msr_o), .resume_o(resume_o)
    );

    typedef struct packed {
        logic [31:0] pc;
        logic [1:0]  kind;
        logic [3:0]  cond;
        logic [1:0]  fp;
        logic        take;
        logic [3:0]  vec;
        logic [4:0]  cause;
        logic [31:0] spc;
        logic        ret;
    } row_t;

    // R2, R4, R10: one instruction per row, floating-point mode varied
    localparam row_t TBL [7] = '{
        '{32'h100, 2'd0, 4'b0001, 2'd0, 1'b1, 4'd4,  5'h10, 32'h100, 1'b0},
        '{32'h200, 2'd0, 4'b0100, 2'd1, 1'b1, 4'd5,  5'h12, 32'h200, 1'b0},
        '{32'h300, 2'd0, 4'b1000, 2'd2, 1'b1, 4'd5,  5'h13, 32'h300, 1'b0},
        '{32'h400, 2'd1, 4'b0000, 2'd3, 1'b1, 4'd12, 5'h04, 32'h404, 1'b1},
        '{32'h500, 2'd2, 4'b0000, 2'd0, 1'b1, 4'd13, 5'h05, 32'h504, 1'b1},
        '{32'h600, 2'd0, 4'b0010, 2'd3, 1'b1, 4'd4,  5'h11, 32'h600, 1'b0},
        '{32'h680, 2'd0, 4'b0000, 2'd1, 1'b0, 4'd0,  5'h00, 32'h000, 1'b1}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        ret_valid_i = 1'b0; ret_pc_i = '0; ret_kind_i = '0; ret_cond_i = '0;
        irq_i = '0; rfe_i = 1'b0; mchk_i = 1'b0; rst_req_i = 1'b0; fp_mode_i = '0;
    endtask

    task automatic retire(input logic [31:0] pc, input logic [1:0] kind, input logic [3:0] cond);
        ret_valid_i = 1'b1; ret_pc_i = pc; ret_kind_i = kind; ret_cond_i = cond;
    endtask

    task automatic do_rfe(input string req);
        idle();
        rfe_i = 1'b1;
        tick();
        rfe_i = 1'b0;
        check({req, " resume"}, 64'(resume_o), 64'd1);
    endtask

    task automatic expect_take(input string req, input logic [3:0] v,
                               input logic [4:0] c, input logic [31:0] spc);
        check({req, " take"}, 64'(take_o), 64'd1);
        check({req, " flush"}, 64'(flush_o), 64'd1);
        check({req, " vec"}, 64'(vec_o), 64'(v));
        check({req, " cause"}, 64'(cause_o), 64'(c));
        check({req, " srr_pc"}, 64'(srr_pc_o), 64'(spc));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1;
        // R1: values held in reset
        check("R1 take", 64'(take_o), 64'd0);
        check("R1 msr", 64'(msr_o), 64'h01);
        rst_n = 1'b1;
        tick();
        check("R1 flush", 64'(flush_o), 64'd0);
        check("R1 resume", 64'(resume_o), 64'd0);
        check("R1 srr_pc", 64'(srr_pc_o), 64'd0);
        check("R1 srr_msr", 64'(srr_msr_o), 64'd0);

        // table walk
        foreach (TBL[k]) begin
            retire(TBL[k].pc, TBL[k].kind, TBL[k].cond);
            fp_mode_i = TBL[k].fp;
            #1;
            check("R2/R4/R10 retire_ok", 64'(retire_ok_o), 64'(TBL[k].ret));
            tick();
            idle();
            if (TBL[k].take) begin
                expect_take("R2/R4/R10", TBL[k].vec, TBL[k].cause, TBL[k].spc);
                check("R7 srr_msr", 64'(srr_msr_o), 64'h01);
                check("R7 ee cleared", 64'(msr_o), 64'h00);
                do_rfe("R8");
                check("R8 msr restored", 64'(msr_o), 64'h01);
                check("R8 resume addr", 64'(srr_pc_o), 64'(TBL[k].spc));
            end else begin
                check("R2 no take", 64'(take_o), 64'd0);
            end
        end

        // R3: two faults on one instruction, delivered one per entry
        retire(32'h700, 2'd0, 4'b0101);
        tick();
        idle();
        expect_take("R3 first", 4'd4, 5'h10, 32'h700);
        tick();
        check("R3 waits for handler", 64'(take_o), 64'd0);
        do_rfe("R3");
        tick();
        expect_take("R3 second", 4'd5, 5'h12, 32'h700);
        do_rfe("R3");
        tick();
        tick();
        check("R3 delivered once", 64'(take_o), 64'd0);

        // R5: interrupt held while store queue busy
        sq_empty_i = 1'b0;
        irq_i = 2'b10;
        tick();
        irq_i = 2'b00;
        tick();
        tick();
        check("R5 held for drain", 64'(take_o), 64'd0);
        sq_empty_i = 1'b1;
        retire(32'h800, 2'd0, 4'b0000);
        #1;
        check("R5 retire_ok", 64'(retire_ok_o), 64'd1);
        tick();
        idle();
        expect_take("R5", 4'd3, 5'h09, 32'h804);
        do_rfe("R5");

        // R6: fault and eligible interrupt in the same cycle
        sq_empty_i = 1'b0;
        irq_i = 2'b01;
        tick();
        irq_i = 2'b00;
        sq_empty_i = 1'b1;
        retire(32'h900, 2'd0, 4'b0010);
        #1;
        check("R6 retire_ok", 64'(retire_ok_o), 64'd0);
        tick();
        idle();
        expect_take("R6 fault first", 4'd4, 5'h11, 32'h900);
        tick();
        tick();
        check("R6 irq masked in handler", 64'(take_o), 64'd0);
        do_rfe("R6");
        tick();
        expect_take("R6 irq later", 4'd3, 5'h08, 32'h900);
        do_rfe("R6");

        // R9: machine check inside a handler, then reset over pending faults
        retire(32'hA00, 2'd0, 4'b0001);
        tick();
        idle();
        check("R9 setup take", 64'(take_o), 64'd1);
        mchk_i = 1'b1;
        retire(32'hA04, 2'd0, 4'b0000);
        #1;
        check("R9 mchk blocks retire", 64'(retire_ok_o), 64'd0);
        tick();
        idle();
        expect_take("R9 mchk", 4'd2, 5'h02, 32'hA04);
        retire(32'hB00, 2'd0, 4'b0110);
        tick();
        idle();
        check("R9 nested fault cause", 64'(cause_o), 64'h11);
        rst_req_i = 1'b1;
        mchk_i = 1'b1;
        retire(32'hC00, 2'd0, 4'b0000);
        tick();
        idle();
        expect_take("R9 reset", 4'd1, 5'h01, 32'hC00);
        do_rfe("R9");
        tick();
        tick();
        check("R9 pending discarded", 64'(take_o), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule